// File: doc/BRIEF.md
# Trace Skid FIFO with Boundary-Aligned Stall

This block sits between a processor core and a narrow trace export path. The core writes 32-bit trace words with a strobe. The block stores them in a 64-entry FIFO and hands them out one per cycle over a valid/ready pair. The stored level is compared with a watermark that can be reprogrammed. When the level reaches the watermark, a full flag rises and the block asks the core to stall so that no trace is lost.

The watermark never exceeds the depth minus a skid allowance of 16 words. A multi-word load or store that is already under way therefore still fits after the flag rises. The stall request may only begin on a cycle the core marks as an instruction boundary. Once begun, it is held for as long as the flag stays up. A pending interrupt request of either kind suppresses the stall unless the interrupt-mask control bit is set. A global enable input turns the whole path off to save power.

Top module: `trace_skid_fifo`

## Requirements
- R1: While `trc_en` is 0, `out_valid` is 0, `out_data` is 0 and `stall_req` is 0. Write strobes are ignored and nothing is drained. The stored contents survive until the block is enabled again.
- R2: `full_flag` is 1 in every cycle where the stored level is greater than or equal to the current watermark.
- R3: `full_flag` is 0 from the first cycle where the level is below the watermark. There is no hysteresis.
- R4: `stall_req` can rise only in a cycle where `insn_bnd` is 1. When the stall has been dropped (for example by an interrupt), it stays low until the next boundary.
- R5: Once raised, `stall_req` stays 1 while `full_flag` is 1, the block is enabled and no unmasked interrupt is pending. It falls in the same cycle that `full_flag` falls.
- R6: While `irq_pend` or `fiq_pend` is 1 and `irq_mask` is 0, `stall_req` is 0. When `irq_mask` is 1, the interrupt lines have no effect on `stall_req`.
- R7: With the watermark at its maximum of 48, 16 further words written after `full_flag` rises are all stored and later drained in order, without setting `ovf_flag`. Writes made while stalled are accepted.
- R8: A watermark write (`wm_wr`=1) loads `wm_val` when it is at most 48 and loads 48 otherwise. The new value takes effect from the next cycle.
- R9: A write while the FIFO holds 64 words is dropped and sets `ovf_flag`. The flag stays set until reset or until `ovf_clr` is pulsed. A set in the same cycle as `ovf_clr` wins.
- R10: A write and a drain in the same cycle leave the level unchanged and keep both words in the correct order.
- R11: Synchronous active-high `rst` empties the FIFO, clears `ovf_flag`, drops `stall_req` and sets the watermark to 32.
- R12: Words leave in write order. A word is drained when `out_valid` and `out_ready` are both 1. While `out_ready` is 0, `out_valid` and `out_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trc_en | input | 1 | Global trace enable |
| wr_stb | input | 1 | Trace word write strobe |
| wr_data | input | 32 | Trace word |
| insn_bnd | input | 1 | Instruction boundary marker from the core |
| irq_pend | input | 1 | Normal interrupt pending |
| fiq_pend | input | 1 | Fast interrupt pending |
| irq_mask | input | 1 | 1: interrupts do not suppress stalling |
| wm_wr | input | 1 | Watermark load strobe |
| wm_val | input | 7 | Requested watermark (clamped to 48) |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| out_ready | input | 1 | Downstream ready |
| out_valid | output | 1 | Head word is available |
| out_data | output | 32 | Head word, 0 when not valid |
| full_flag | output | 1 | Level at or above watermark |
| stall_req | output | 1 | Stall request to the core |
| ovf_flag | output | 1 | Sticky overflow indicator |

## Verification
A write and a drain can land in the same cycle. The bench provokes this with the FIFO sitting exactly at the watermark, holding `wr_stb` and `out_ready` high together for several cycles. It judges the result by `full_flag` staying at 1 and by every drained word matching a queue model kept in the bench. A second collision is an interrupt arriving on the same cycle as a boundary while the flag is up. The bench checks that `stall_req` stays 0 with the mask clear and rises once the interrupt line drops.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

   // Bound a requested watermark to the highest value that still leaves skid room.
   function automatic int unsigned wm_limit(input int unsigned req, input int unsigned lim);
      return (req > lim) ? lim : req;
   endfunction

   // True when n is a nonzero power of two.
   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/tsf_store.sv
module tsf_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push_req,
   input  logic              pop_req,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] head,
   output logic [CW-1:0]     level,
   output logic              drop
);
   import tsf_pkg::*;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nx, rd_nx;
   logic              push_ok, pop_ok, is_full, is_empty;

   assign is_full  = (level == CW'(DEPTH));
   assign is_empty = (level == '0);
   assign push_ok  = push_req & ~is_full;
   assign pop_ok   = pop_req & ~is_empty;
   assign drop     = push_req & is_full;

   generate
      if (is_pow2(DEPTH)) begin : g_pow2_wrap
         assign wr_nx = wr_ptr + 1'b1;
         assign rd_nx = rd_ptr + 1'b1;
      end else begin : g_cmp_wrap
         assign wr_nx = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nx = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nx;
         if (pop_ok)  rd_ptr <= rd_nx;
         if (push_ok && !pop_ok)      level <= level + 1'b1;
         else if (pop_ok && !push_ok) level <= level - 1'b1;
      end
   end

   assign head = mem[rd_ptr];

endmodule

// File: rtl/tsf_watermark.sv
module tsf_watermark #(
   parameter int unsigned DEPTH   = 64,
   parameter int unsigned SKID    = 16,
   parameter int unsigned WM_INIT = 32,
   localparam int unsigned CW     = $clog2(DEPTH + 1),
   localparam int unsigned WM_MAX = DEPTH - SKID
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wm_wr,
   input  logic [CW-1:0] wm_val,
   input  logic [CW-1:0] level,
   output logic [CW-1:0] wm_cur,
   output logic          full_flag
);
   import tsf_pkg::*;

   localparam logic [CW-1:0] WM_CAP = CW'(WM_MAX);
   localparam logic [CW-1:0] WM_RST = CW'(wm_limit(WM_INIT, WM_MAX));

   always_ff @(posedge clk) begin
      if (rst)        wm_cur <= WM_RST;
      else if (wm_wr) wm_cur <= (wm_val > WM_CAP) ? WM_CAP : wm_val;
   end

   assign full_flag = (level >= wm_cur);

endmodule

// File: rtl/tsf_stall.sv
module tsf_stall (
   input  logic clk,
   input  logic rst,
   input  logic trc_en,
   input  logic full_flag,
   input  logic insn_bnd,
   input  logic irq_pend,
   input  logic fiq_pend,
   input  logic irq_mask,
   output logic stall_req
);
   logic veto, armed, held_q;

   assign veto      = (irq_pend | fiq_pend) & ~irq_mask;
   assign armed     = trc_en & full_flag & ~veto;
   assign stall_req = armed & (held_q | insn_bnd);

   always_ff @(posedge clk) begin
      if (rst) held_q <= 1'b0;
      else     held_q <= stall_req;
   end

endmodule

// File: rtl/trace_skid_fifo.sv
module trace_skid_fifo #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned DEPTH   = 64,
   parameter int unsigned SKID    = 16,
   parameter int unsigned WM_INIT = 32,
   localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              trc_en,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              insn_bnd,
   input  logic              irq_pend,
   input  logic              fiq_pend,
   input  logic              irq_mask,
   input  logic              wm_wr,
   input  logic [CW-1:0]     wm_val,
   input  logic              ovf_clr,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              full_flag,
   output logic              stall_req,
   output logic              ovf_flag
);

   initial begin
      assert (DEPTH >= 2) else $error("trace_skid_fifo: DEPTH must be at least 2");
      assert (SKID < DEPTH) else $error("trace_skid_fifo: SKID must be below DEPTH");
      assert (WM_INIT <= DEPTH - SKID) else $error("trace_skid_fifo: WM_INIT exceeds DEPTH-SKID");
      assert (DATA_W > 0) else $error("trace_skid_fifo: DATA_W must be positive");
   end

   logic [CW-1:0]     level, wm_cur;
   logic [DATA_W-1:0] head;
   logic              push_req, pop_req, drop;

   assign push_req  = trc_en & wr_stb;
   assign out_valid = trc_en & (level != '0);
   assign pop_req   = out_valid & out_ready;
   assign out_data  = out_valid ? head : '0;

   tsf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
      .wdata(wr_data), .head(head), .level(level), .drop(drop)
   );

   tsf_watermark #(.DEPTH(DEPTH), .SKID(SKID), .WM_INIT(WM_INIT)) u_wm (
      .clk(clk), .rst(rst), .wm_wr(wm_wr), .wm_val(wm_val),
      .level(level), .wm_cur(wm_cur), .full_flag(full_flag)
   );

   tsf_stall u_stall (
      .clk(clk), .rst(rst), .trc_en(trc_en), .full_flag(full_flag),
      .insn_bnd(insn_bnd), .irq_pend(irq_pend), .fiq_pend(fiq_pend),
      .irq_mask(irq_mask), .stall_req(stall_req)
   );

   always_ff @(posedge clk) begin
      if (rst)          ovf_flag <= 1'b0;
      else if (drop)    ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
   end

endmodule

// File: rtl/tsf_checker.sv
module tsf_checker #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned DEPTH   = 64,
   parameter int unsigned SKID    = 16,
   parameter int unsigned WM_INIT = 32,
   localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic              trc_en,
   input logic              wr_stb,
   input logic              insn_bnd,
   input logic              irq_pend,
   input logic              fiq_pend,
   input logic              irq_mask,
   input logic              wm_wr,
   input logic [CW-1:0]     wm_val,
   input logic              ovf_clr,
   input logic              out_ready,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              full_flag,
   input logic              stall_req,
   input logic              ovf_flag,
   input logic [CW-1:0]     level,
   input logic [CW-1:0]     wm_cur
);
   localparam logic [CW-1:0] WM_CAP = CW'(DEPTH - SKID);
   localparam logic [CW-1:0] WM_RST = CW'(WM_INIT);
   localparam logic [CW-1:0] LV_TOP = CW'(DEPTH);

   logic veto;
   assign veto = (irq_pend || fiq_pend) && !irq_mask;

   p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (rst)
      !trc_en |-> (!out_valid && out_data == '0 && !stall_req));

   p_full_rises_at_wm_r2: assert property (@(posedge clk) disable iff (rst)
      ($rose(full_flag) && $stable(wm_cur)) |-> (level == wm_cur));

   p_full_falls_below_r3: assert property (@(posedge clk) disable iff (rst)
      ($fell(full_flag) && $stable(wm_cur)) |-> (level == wm_cur - 1'b1));

   p_stall_starts_on_bnd_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(stall_req) |-> insn_bnd);

   p_stall_needs_full_r5: assert property (@(posedge clk) disable iff (rst)
      !full_flag |-> !stall_req);

   p_stall_held_r5: assert property (@(posedge clk) disable iff (rst)
      stall_req ##1 (trc_en && full_flag && !veto) |-> stall_req);

   p_irq_veto_r6: assert property (@(posedge clk) disable iff (rst)
      veto |-> !stall_req);

   p_skid_room_r7: assert property (@(posedge clk) disable iff (rst)
      wm_cur <= WM_CAP);

   p_wm_clamp_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wm_wr) && $past(wm_val) > WM_CAP) |-> (wm_cur == WM_CAP));

   p_ovf_set_r9: assert property (@(posedge clk) disable iff (rst)
      (trc_en && wr_stb && level == LV_TOP) |=> ovf_flag);

   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      (ovf_flag && !ovf_clr) |=> ovf_flag);

   p_same_cycle_level_r10: assert property (@(posedge clk) disable iff (rst)
      (trc_en && wr_stb && level != LV_TOP && out_valid && out_ready) |=> $stable(level));

   p_reset_state_r11: assert property (@(posedge clk)
      $past(rst) |-> (level == '0 && !ovf_flag && wm_cur == WM_RST && !stall_req));

   p_hold_when_blocked_r12: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) ##1 trc_en |-> (out_valid && $stable(out_data)));

endmodule

bind trace_skid_fifo tsf_checker #(
   .DATA_W(DATA_W), .DEPTH(DEPTH), .SKID(SKID), .WM_INIT(WM_INIT)
) u_chk (
   .clk(clk), .rst(rst), .trc_en(trc_en), .wr_stb(wr_stb), .insn_bnd(insn_bnd),
   .irq_pend(irq_pend), .fiq_pend(fiq_pend), .irq_mask(irq_mask), .wm_wr(wm_wr),
   .wm_val(wm_val), .ovf_clr(ovf_clr), .out_ready(out_ready), .out_valid(out_valid),
   .out_data(out_data), .full_flag(full_flag), .stall_req(stall_req),
   .ovf_flag(ovf_flag), .level(level), .wm_cur(wm_cur)
);

// File: tb/trace_skid_fifo_tb.sv
module trace_skid_fifo_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 64;
   localparam int WM_MAX     = 48;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        trc_en = 1'b0, wr_stb = 1'b0, insn_bnd = 1'b0;
   logic        irq_pend = 1'b0, fiq_pend = 1'b0, irq_mask = 1'b0;
   logic        wm_wr = 1'b0, ovf_clr = 1'b0, out_ready = 1'b0;
   logic [31:0] wr_data = '0;
   logic [6:0]  wm_val = '0;
   logic        out_valid, full_flag, stall_req, ovf_flag;
   logic [31:0] out_data;

   int n_cmp = 0;
   int n_bad = 0;
   int seq = 0;
   int exp_wm = 32;
   logic exp_ovf = 1'b0;
   logic [31:0] mdl[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   trace_skid_fifo u_dut (
      .clk(clk), .rst(rst), .trc_en(trc_en), .wr_stb(wr_stb), .wr_data(wr_data),
      .insn_bnd(insn_bnd), .irq_pend(irq_pend), .fiq_pend(fiq_pend),
      .irq_mask(irq_mask), .wm_wr(wm_wr), .wm_val(wm_val), .ovf_clr(ovf_clr),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
      .full_flag(full_flag), .stall_req(stall_req), .ovf_flag(ovf_flag)
   );

   task automatic show_summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      show_summary();
      $finish;
   end

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] next_word();
      seq++;
      return {seq[15:0] ^ 16'h5A3C, seq[15:0]};
   endfunction

   task automatic push_word();
      logic [31:0] w;
      w = next_word();
      wr_stb = 1'b1;
      wr_data = w;
      tick();
      wr_stb = 1'b0;
      if (trc_en) begin
         if (mdl.size() < DEPTH) mdl.push_back(w);
         else exp_ovf = 1'b1;
      end
   endtask

   task automatic pop_word(input string tag);
      #1;
      chk({tag, " valid"}, 32'(out_valid), 32'd1);
      chk({tag, " order"}, out_data, mdl[0]);
      out_ready = 1'b1;
      tick();
      out_ready = 1'b0;
      void'(mdl.pop_front());
   endtask

   task automatic drain_all(input string tag);
      while (mdl.size() > 0) pop_word(tag);
      #1;
      chk({tag, " empty"}, 32'(out_valid), 32'd0);
   endtask

   task automatic set_wm(input int v);
      wm_wr = 1'b1;
      wm_val = 7'(v);
      tick();
      wm_wr = 1'b0;
      exp_wm = (v > WM_MAX) ? WM_MAX : v;
   endtask

   task automatic chk_full(input string tag);
      #1;
      chk(tag, 32'(full_flag), 32'(mdl.size() >= exp_wm));
   endtask

   initial begin
      int sweep[10] = '{1, 2, 7, 16, 31, 47, 48, 49, 60, 127};
      tick(); tick(); tick();
      rst = 1'b0;
      #1;
      // R11 reset state
      chk("R11 valid", 32'(out_valid), 32'd0);
      chk("R11 full", 32'(full_flag), 32'd0);
      chk("R11 stall", 32'(stall_req), 32'd0);
      chk("R11 ovf", 32'(ovf_flag), 32'd0);
      trc_en = 1'b1;
      for (int i = 0; i < 32; i++) begin
         push_word();
         chk_full("R11 default watermark 32");
      end
      drain_all("R12");

      // R1 disabled path
      set_wm(4);
      for (int i = 0; i < 5; i++) push_word();
      trc_en = 1'b0;
      insn_bnd = 1'b1;
      #1;
      chk("R1 valid off", 32'(out_valid), 32'd0);
      chk("R1 data off", out_data, 32'd0);
      chk("R1 stall off", 32'(stall_req), 32'd0);
      for (int i = 0; i < 3; i++) push_word();
      out_ready = 1'b1;
      tick();
      out_ready = 1'b0;
      insn_bnd = 1'b0;
      trc_en = 1'b1;
      drain_all("R1 contents kept");

      // R2 R3 R8 watermark sweep
      foreach (sweep[k]) begin
         set_wm(sweep[k]);
         for (int i = 0; i < exp_wm; i++) begin
            push_word();
            chk_full("R2 full at level");
         end
         pop_word("R3");
         chk_full("R3 full drops below");
         chk("R8 clamp", 32'(full_flag), 32'(mdl.size() >= exp_wm));
         drain_all("R12 sweep");
      end

      // R4 R5 R6 stall behaviour
      set_wm(8);
      for (int i = 0; i < 8; i++) push_word();
      #1;
      chk("R4 no boundary", 32'(stall_req), 32'd0);
      insn_bnd = 1'b1;
      #1;
      chk("R4 start at boundary", 32'(stall_req), 32'd1);
      tick();
      insn_bnd = 1'b0;
      #1;
      chk("R5 held", 32'(stall_req), 32'd1);
      push_word();
      push_word();
      #1;
      chk("R7 writes accepted while stalled", 32'(stall_req), 32'd1);
      irq_pend = 1'b1;
      irq_mask = 1'b1;
      #1;
      chk("R6 masked irq", 32'(stall_req), 32'd1);
      irq_mask = 1'b0;
      #1;
      chk("R6 irq veto", 32'(stall_req), 32'd0);
      tick();
      irq_pend = 1'b0;
      #1;
      chk("R4 rearm needs boundary", 32'(stall_req), 32'd0);
      fiq_pend = 1'b1;
      insn_bnd = 1'b1;
      #1;
      chk("R6 fiq veto", 32'(stall_req), 32'd0);
      fiq_pend = 1'b0;
      #1;
      chk("R6 veto lifted", 32'(stall_req), 32'd1);
      tick();
      insn_bnd = 1'b0;
      pop_word("R5");
      pop_word("R5");
      #1;
      chk("R5 still full", 32'(stall_req), 32'd1);
      pop_word("R5");
      #1;
      chk("R5 release", 32'(stall_req), 32'd0);
      chk("R3 full off", 32'(full_flag), 32'd0);
      drain_all("R12 stall");

      // R7 R9 skid room and overflow
      set_wm(48);
      for (int i = 0; i < 48; i++) push_word();
      chk_full("R7 full at 48");
      for (int i = 0; i < 16; i++) begin
         push_word();
         #1;
         chk("R7 skid no overflow", 32'(ovf_flag), 32'd0);
      end
      push_word();
      #1;
      chk("R9 overflow set", 32'(ovf_flag), 32'(exp_ovf));
      drain_all("R7 skid order");
      chk("R9 sticky", 32'(ovf_flag), 32'd1);
      ovf_clr = 1'b1;
      tick();
      ovf_clr = 1'b0;
      #1;
      chk("R9 cleared", 32'(ovf_flag), 32'd0);

      // R10 simultaneous write and drain at the watermark
      set_wm(8);
      for (int i = 0; i < 8; i++) push_word();
      for (int i = 0; i < 5; i++) begin
         logic [31:0] w;
         w = next_word();
         #1;
         chk("R10 head", out_data, mdl[0]);
         wr_stb = 1'b1;
         wr_data = w;
         out_ready = 1'b1;
         tick();
         void'(mdl.pop_front());
         mdl.push_back(w);
         chk_full("R10 level kept");
      end
      wr_stb = 1'b0;
      out_ready = 1'b0;
      drain_all("R10 order");

      // R12 hold while blocked
      push_word();
      #1;
      chk("R12 valid", 32'(out_valid), 32'd1);
      tick();
      tick();
      chk("R12 hold valid", 32'(out_valid), 32'd1);
      chk("R12 hold data", out_data, mdl[0]);
      drain_all("R12");

      // R11 reset in the middle of a run
      set_wm(5);
      for (int i = 0; i < 3; i++) push_word();
      rst = 1'b1;
      tick();
      rst = 1'b0;
      mdl.delete();
      exp_wm = 32;
      #1;
      chk("R11 flushed", 32'(out_valid), 32'd0);
      for (int i = 0; i < 32; i++) push_word();
      chk_full("R11 watermark back to 32");
      drain_all("R11");

      show_summary();
      $finish;
   end
endmodule